// File: doc/BRIEF.md
# Per-Channel Echo Canceller Disable Controller

This block decides, channel by channel, how much of an echo canceller stays in the signal path. Several causes can each ask for a channel to be bypassed: a 2100 Hz answer tone with or without phase reversal, a 2010 Hz continuity tone, an idle channel, a chosen pattern on the channel's four signalling bits carried in timeslot 16, and an external request bit. Each cause maps through a policy register to one of three graded actions. The mildest turns off only the non-linear processor. The middle one also turns off the echo subtractor. The strongest bypasses the whole canceller.

Tone detectors deliver start and end pulses per channel, and the block keeps a latch for each tone. The timeslot 16 octet of each frame of the signalling multiframe is written into a per-channel store. The combined action of a channel is re-evaluated only when the time-division schedule presents that channel's slot. When a channel leaves full bypass, the block pulses a reset for that channel's echo-path coefficients, so adaptation restarts from a clean state. A long-tail mode bit halves the number of active channels.

Top module: `ec_bypass_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every disable output and every coefficient reset strobe is low.
- R2: The action level of a channel is graded. Level 1 raises only `dis_nlp`. Level 2 raises `dis_nlp` and `dis_sub`. Level 3 raises `dis_nlp`, `dis_sub` and `bypass`. Level 0 raises none of them.
- R3: At its slot, a channel takes the highest level requested by all of its causes that are active at that time.
- R4: A channel's outputs change only in the clock cycle after a `slot_stb` that carries its index. The one exception is the long-tail clearing of R10.
- R5: Each tone latch is set by its start pulse and held until its end pulse. When both pulses arrive in the same cycle, the start pulse wins.
- R6: The policy register (address 0) holds one 2-bit action per cause: plain tone [1:0], reversal tone [3:2], continuity [5:4], signalling [7:6], idle [9:8], external [11:10]. Bit 16 of the same register is the long-tail mode. Reset value 0x00000F3D: plain tone gives level 1, signalling gives level 0, every other cause gives level 3.
- R7: A timeslot 16 octet of multiframe frame f, with f from 1 to 15, stores its upper nibble for channel f and its lower nibble for channel f+15. Frame 0 stores nothing.
- R8: The signalling cause is active when ((abcd XOR pattern) AND mask) is zero. Pattern is bits [3:0] and mask is bits [7:4] of register address 1. Both reset to zero.
- R9: Register address 2 holds one external disable bit per channel, bit n for channel n, reset 0.
- R10: While long-tail mode is set, channels NCH/2 and above are held at level 0 from the next cycle, and their slot strobes have no effect.
- R11: `coef_rst[n]` pulses for one cycle, in the same cycle the outputs change, when channel n's level drops from 3 to a lower value at its slot. It never pulses for a channel cleared by long-tail mode.
- R12: A write to register address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| slot_stb | input | 1 | Channel slot boundary |
| slot_ch | input | CW | Channel index of this slot |
| ts16_vld | input | 1 | Timeslot 16 octet valid |
| ts16_frame | input | 4 | Multiframe frame number of the octet |
| ts16_byte | input | 8 | Timeslot 16 octet |
| tone_pl_on | input | NCH | Plain 2100 Hz tone start pulses |
| tone_pl_off | input | NCH | Plain 2100 Hz tone end pulses |
| tone_pr_on | input | NCH | Phase-reversed 2100 Hz tone start pulses |
| tone_pr_off | input | NCH | Phase-reversed 2100 Hz tone end pulses |
| tone_cc_on | input | NCH | 2010 Hz continuity tone start pulses |
| tone_cc_off | input | NCH | 2010 Hz continuity tone end pulses |
| idle_det | input | NCH | Idle channel flags |
| dis_nlp | output | NCH | Non-linear processor off |
| dis_sub | output | NCH | Subtractor off |
| bypass | output | NCH | Whole canceller bypassed |
| coef_rst | output | NCH | Coefficient reset strobe |

## Verification
Directed sequences raise one cause at a time on a single channel. They show that each cause reaches the level its policy gives, and that a tone latch keeps the disable alive between the start and end pulses until the next slot. A signalling case writes one octet carrying two different nibbles. It shows the upper and lower channel mapping, and it shows that frame 0 is not stored. Other cases exit full bypass to pin the strobe's cycle, and toggle long-tail mode to tell cleared channels apart from active ones. A long random run overlaps all causes, policy rewrites and sparse slots, which separates correct maximum combining and slot-only updating from the alternatives.

// File: rtl/ecd_pkg.sv
`timescale 1ns/1ps
// Shared types for the echo canceller disable controller.
package ecd_pkg;
    // Graded disable action, ordered so a larger value is stronger.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_NLP  = 2'd1,
        ACT_SUB  = 2'd2,
        ACT_FULL = 2'd3
    } act_e;

    localparam int NTONE  = 3;          // plain, reversal, continuity
    localparam int POL_W  = 12;         // six causes x 2 bits
    localparam logic [POL_W-1:0] POL_RST = 12'hF3D;

    // Strongest of two actions.
    function automatic act_e act_max(act_e a, act_e b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ecd_cfg_regs.sv
`timescale 1ns/1ps
// Policy, signalling pattern and external-disable registers.
// Assumes single-cycle writes; address 3 is unused and ignored.
module ecd_cfg_regs
    import ecd_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [POL_W-1:0] pol,
    output logic             long_tail,
    output logic [3:0]       sig_pat,
    output logic [3:0]       sig_msk,
    output logic [NCH-1:0]   ext_dis
);
    // Register writes with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol       <= POL_RST;
            long_tail <= 1'b0;
            sig_pat   <= '0;
            sig_msk   <= '0;
            ext_dis   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin
                    pol       <= cfg_wdata[POL_W-1:0];
                    long_tail <= cfg_wdata[16];
                end
                2'd1: begin
                    sig_pat <= cfg_wdata[3:0];
                    sig_msk <= cfg_wdata[7:4];
                end
                2'd2: ext_dis <= cfg_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecd_tone_latch.sv
`timescale 1ns/1ps
// Per-channel hold of tone detections, one latch row per tone type.
// A start pulse sets the latch and wins over a simultaneous end pulse.
module ecd_tone_latch
    import ecd_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NTONE-1:0][NCH-1:0] on_p,
    input  logic [NTONE-1:0][NCH-1:0] off_p,
    output logic [NTONE-1:0][NCH-1:0] lat
);
    for (genvar k = 0; k < NTONE; k++) begin : g_tone
        // Set on start, clear on end, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) lat[k] <= '0;
            else        lat[k] <= on_p[k] | (lat[k] & ~off_p[k]);
        end
    end
endmodule

// File: rtl/ecd_ts16_store.sv
`timescale 1ns/1ps
// Stores the abcd signalling nibbles from timeslot 16 octets.
// Frame f (1..15): upper nibble -> channel f, lower nibble -> channel f+15.
module ecd_ts16_store #(
    parameter int NCH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ts16_vld,
    input  logic [3:0]          ts16_frame,
    input  logic [7:0]          ts16_byte,
    output logic [NCH-1:0][3:0] abcd
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Capture this channel's nibble when its frame passes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                abcd[ch] <= 4'd0;
            end else if (ts16_vld && ts16_frame != 4'd0) begin
                if (int'(ts16_frame) == ch)
                    abcd[ch] <= ts16_byte[7:4];
                else if (int'(ts16_frame) + 15 == ch)
                    abcd[ch] <= ts16_byte[3:0];
            end
        end
    end
endmodule

// File: rtl/ecd_chan_state.sv
`timescale 1ns/1ps
// Per-channel action level, updated only at that channel's slot.
// Combines all causes of the slot channel to the strongest action and
// strobes a coefficient reset when a channel leaves full bypass.
module ecd_chan_state
    import ecd_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CW  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slot_stb,
    input  logic [CW-1:0]             slot_ch,
    input  logic                      long_tail,
    input  logic [POL_W-1:0]          pol,
    input  logic [3:0]                sig_pat,
    input  logic [3:0]                sig_msk,
    input  logic [NTONE-1:0][NCH-1:0] tone_lat,
    input  logic [NCH-1:0][3:0]       abcd,
    input  logic [NCH-1:0]            idle_det,
    input  logic [NCH-1:0]            ext_dis,
    output logic [NCH-1:0]            dis_nlp,
    output logic [NCH-1:0]            dis_sub,
    output logic [NCH-1:0]            bypass,
    output logic [NCH-1:0]            coef_rst
);
    localparam int HALF = NCH / 2;

    act_e new_act;
    act_e lvl [NCH];

    // Strongest action over every active cause of the slot channel.
    always_comb begin
        int idx;
        idx     = int'(slot_ch);
        new_act = ACT_NONE;
        if (idx < NCH) begin
            for (int k = 0; k < NTONE; k++)
                if (tone_lat[k][idx])
                    new_act = act_max(new_act, act_e'(pol[2*k +: 2]));
            if (((abcd[idx] ^ sig_pat) & sig_msk) == 4'd0)
                new_act = act_max(new_act, act_e'(pol[7:6]));
            if (idle_det[idx])
                new_act = act_max(new_act, act_e'(pol[9:8]));
            if (ext_dis[idx])
                new_act = act_max(new_act, act_e'(pol[11:10]));
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam bit UPPER = (ch >= HALF);

        // Level register and coefficient reset strobe of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl[ch]      <= ACT_NONE;
                coef_rst[ch] <= 1'b0;
            end else begin
                coef_rst[ch] <= 1'b0;
                if (UPPER && long_tail) begin
                    lvl[ch] <= ACT_NONE;
                end else if (slot_stb && int'(slot_ch) == ch) begin
                    lvl[ch]      <= new_act;
                    coef_rst[ch] <= (lvl[ch] == ACT_FULL) && (new_act != ACT_FULL);
                end
            end
        end

        // Graded decode of the level into the three controls.
        always_comb begin
            dis_nlp[ch] = (lvl[ch] != ACT_NONE);
            dis_sub[ch] = (lvl[ch] == ACT_SUB) || (lvl[ch] == ACT_FULL);
            bypass[ch]  = (lvl[ch] == ACT_FULL);
        end
    end
endmodule

// File: rtl/ec_bypass_ctrl.sv
`timescale 1ns/1ps
// Top of the per-channel echo canceller disable controller.
// Assumes one channel slot per strobe and detector pulses one cycle wide.
module ec_bypass_ctrl
    import ecd_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [31:0]    cfg_wdata,
    input  logic           slot_stb,
    input  logic [CW-1:0]  slot_ch,
    input  logic           ts16_vld,
    input  logic [3:0]     ts16_frame,
    input  logic [7:0]     ts16_byte,
    input  logic [NCH-1:0] tone_pl_on,
    input  logic [NCH-1:0] tone_pl_off,
    input  logic [NCH-1:0] tone_pr_on,
    input  logic [NCH-1:0] tone_pr_off,
    input  logic [NCH-1:0] tone_cc_on,
    input  logic [NCH-1:0] tone_cc_off,
    input  logic [NCH-1:0] idle_det,
    output logic [NCH-1:0] dis_nlp,
    output logic [NCH-1:0] dis_sub,
    output logic [NCH-1:0] bypass,
    output logic [NCH-1:0] coef_rst
);
    logic [POL_W-1:0]          pol;
    logic                      cfg_lt;
    logic [3:0]                sig_pat, sig_msk;
    logic [NCH-1:0]            ext_dis;
    logic [NTONE-1:0][NCH-1:0] tone_on_v, tone_off_v, tone_lat_v;
    logic [NCH-1:0][3:0]       abcd;

    // Tone rows ordered as the policy fields: plain, reversal, continuity.
    always_comb begin
        tone_on_v  = {tone_cc_on,  tone_pr_on,  tone_pl_on};
        tone_off_v = {tone_cc_off, tone_pr_off, tone_pl_off};
    end

    ecd_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pol(pol), .long_tail(cfg_lt),
        .sig_pat(sig_pat), .sig_msk(sig_msk), .ext_dis(ext_dis)
    );

    ecd_tone_latch #(.NCH(NCH)) u_tone (
        .clk(clk), .rst_n(rst_n), .on_p(tone_on_v), .off_p(tone_off_v),
        .lat(tone_lat_v)
    );

    ecd_ts16_store #(.NCH(NCH)) u_ts16 (
        .clk(clk), .rst_n(rst_n), .ts16_vld(ts16_vld), .ts16_frame(ts16_frame),
        .ts16_byte(ts16_byte), .abcd(abcd)
    );

    ecd_chan_state #(.NCH(NCH), .CW(CW)) u_state (
        .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_ch(slot_ch),
        .long_tail(cfg_lt), .pol(pol), .sig_pat(sig_pat), .sig_msk(sig_msk),
        .tone_lat(tone_lat_v), .abcd(abcd), .idle_det(idle_det),
        .ext_dis(ext_dis), .dis_nlp(dis_nlp), .dis_sub(dis_sub),
        .bypass(bypass), .coef_rst(coef_rst)
    );
endmodule

// File: rtl/ecd_checker.sv
`timescale 1ns/1ps
// Properties of the disable controller, bound into the top module.
module ecd_checker
    import ecd_pkg::*;
#(
    parameter int NCH = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      slot_stb,
    input logic                      long_tail,
    input logic [NTONE-1:0][NCH-1:0] tone_on,
    input logic [NTONE-1:0][NCH-1:0] tone_lat,
    input logic [NCH-1:0]            dis_nlp,
    input logic [NCH-1:0]            dis_sub,
    input logic [NCH-1:0]            bypass,
    input logic [NCH-1:0]            coef_rst
);
    localparam int HALF = NCH / 2;

    a_r2_graded: assert property (@(posedge clk) disable iff (!rst_n)
        ((bypass & ~dis_sub) == '0) && ((dis_sub & ~dis_nlp) == '0));

    a_r4_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_stb && !long_tail) |=>
            ($stable(dis_nlp) && $stable(dis_sub) && $stable(bypass)));

    a_r5_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on != '0) |=> ((tone_lat & $past(tone_on)) == $past(tone_on)));

    a_r10_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        long_tail |=> (dis_nlp[NCH-1:HALF] == '0));

    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(coef_rst));

    a_r11_leaves_full: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rst != '0) |-> (((coef_rst & bypass) == '0) &&
                              ((coef_rst & ~$past(bypass)) == '0)));
endmodule

bind ec_bypass_ctrl ecd_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .long_tail(cfg_lt),
    .tone_on(tone_on_v), .tone_lat(tone_lat_v), .dis_nlp(dis_nlp),
    .dis_sub(dis_sub), .bypass(bypass), .coef_rst(coef_rst)
);

// File: tb/sim_ec_bypass_ctrl.sv
`timescale 1ns/1ps
module sim_ec_bypass_ctrl;
    localparam int NCH = 32;
    localparam int CW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic slot_stb = 1'b0;
    logic [CW-1:0] slot_ch = '0;
    logic ts16_vld = 1'b0;
    logic [3:0] ts16_frame = '0;
    logic [7:0] ts16_byte = '0;
    logic [NCH-1:0] pl_on = '0, pl_off = '0, pr_on = '0, pr_off = '0;
    logic [NCH-1:0] cc_on = '0, cc_off = '0, idle = '0;
    logic [NCH-1:0] dis_nlp, dis_sub, bypass, coef_rst;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    ec_bypass_ctrl #(.NCH(NCH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slot_stb(slot_stb), .slot_ch(slot_ch),
        .ts16_vld(ts16_vld), .ts16_frame(ts16_frame), .ts16_byte(ts16_byte),
        .tone_pl_on(pl_on), .tone_pl_off(pl_off), .tone_pr_on(pr_on),
        .tone_pr_off(pr_off), .tone_cc_on(cc_on), .tone_cc_off(cc_off),
        .idle_det(idle), .dis_nlp(dis_nlp), .dis_sub(dis_sub),
        .bypass(bypass), .coef_rst(coef_rst)
    );

    // Reference model state.
    logic [NCH-1:0] m_lat [3];
    logic [3:0]  m_abcd [NCH];
    logic [1:0]  m_lvl [NCH];
    logic [11:0] m_pol;
    logic        m_lt;
    logic [3:0]  m_pat, m_msk;
    logic [NCH-1:0] m_ext, m_crst;

    function automatic logic [1:0] mx(logic [1:0] a, logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [1:0] calc(int ch);
        logic [1:0] l = 2'd0;
        for (int k = 0; k < 3; k++) if (m_lat[k][ch]) l = mx(l, m_pol[2*k +: 2]);
        if (((m_abcd[ch] ^ m_pat) & m_msk) == 4'd0) l = mx(l, m_pol[7:6]);
        if (idle[ch])  l = mx(l, m_pol[9:8]);
        if (m_ext[ch]) l = mx(l, m_pol[11:10]);
        return l;
    endfunction

    function automatic logic [4*NCH-1:0] exp_out();
        logic [NCH-1:0] n, s, b;
        for (int ch = 0; ch < NCH; ch++) begin
            n[ch] = m_lvl[ch] != 2'd0;
            s[ch] = m_lvl[ch] >= 2'd2;
            b[ch] = m_lvl[ch] == 2'd3;
        end
        return {n, s, b, m_crst};
    endfunction

    // Model update at each edge, old state first, then inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) m_lat[k] = '0;
            for (int ch = 0; ch < NCH; ch++) begin m_abcd[ch] = 0; m_lvl[ch] = 0; end
            m_pol = 12'hF3D; m_lt = 0; m_pat = 0; m_msk = 0; m_ext = '0; m_crst = '0;
        end else begin
            m_crst = '0;
            for (int ch = 0; ch < NCH; ch++) begin
                if (m_lt && ch >= NCH/2) m_lvl[ch] = 2'd0;
                else if (slot_stb && int'(slot_ch) == ch) begin
                    logic [1:0] nl;
                    nl = calc(ch);
                    m_crst[ch] = (m_lvl[ch] == 2'd3) && (nl != 2'd3);
                    m_lvl[ch] = nl;
                end
            end
            m_lat[0] = pl_on | (m_lat[0] & ~pl_off);
            m_lat[1] = pr_on | (m_lat[1] & ~pr_off);
            m_lat[2] = cc_on | (m_lat[2] & ~cc_off);
            if (ts16_vld && ts16_frame != 0) begin
                m_abcd[ts16_frame] = ts16_byte[7:4];
                if (int'(ts16_frame) + 15 < NCH) m_abcd[ts16_frame + 15] = ts16_byte[3:0];
            end
            if (cfg_we) case (cfg_addr)
                2'd0: begin m_pol = cfg_wdata[11:0]; m_lt = cfg_wdata[16]; end
                2'd1: begin m_pat = cfg_wdata[3:0]; m_msk = cfg_wdata[7:4]; end
                2'd2: m_ext = cfg_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Whole-output comparison against the model away from the edge.
    always @(negedge clk) if (chk_on) begin
        logic [4*NCH-1:0] e;
        e = exp_out();
        n_chk++;
        if ({dis_nlp, dis_sub, bypass, coef_rst} !== e) begin
            n_fail++;
            $display("FAIL %s model: got %h expected %h", tag,
                     {dis_nlp, dis_sub, bypass, coef_rst}, e);
        end
    end

    task automatic chk(string t, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", t, got, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic clear_in();
        cfg_we = 0; slot_stb = 0; ts16_vld = 0;
        pl_on = '0; pl_off = '0; pr_on = '0; pr_off = '0; cc_on = '0; cc_off = '0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); clear_in();
    endtask

    task automatic slot(int ch);
        slot_stb = 1; slot_ch = CW'(ch); tick(); clear_in();
    endtask

    bit done = 0;
    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        repeat (3) tick();
        rst_n = 1; tick(); chk_on = 1;
        // R1: reset state
        tag = "R1";
        chk("R1 nlp", |dis_nlp, 0); chk("R1 byp", |bypass, 0); chk("R1 rst", |coef_rst, 0);

        // R6 R2: plain tone -> NLP only
        tag = "R6";
        pl_on[3] = 1; tick(); clear_in();
        chk("R4 before slot", dis_nlp[3], 0);
        slot(3);
        chk("R6 nlp", dis_nlp[3], 1); chk("R2 sub", dis_sub[3], 0); chk("R2 byp", bypass[3], 0);

        // R5: latch holds until end pulse, then clears at next slot
        tag = "R5";
        repeat (5) tick(); slot(3);
        chk("R5 held", dis_nlp[3], 1);
        pl_off[3] = 1; tick(); clear_in();
        chk("R4 held to slot", dis_nlp[3], 1);
        slot(3);
        chk("R5 cleared", dis_nlp[3], 0);
        pr_on[6] = 1; pr_off[6] = 1; tick(); clear_in(); slot(6);
        chk("R5 start wins", bypass[6], 1);

        // R11: leave full bypass
        tag = "R11";
        pr_off[6] = 1; tick(); clear_in();
        slot_stb = 1; slot_ch = 6; tick(); clear_in();
        chk("R11 strobe", coef_rst[6], 1); chk("R11 byp off", bypass[6], 0);
        tick(); chk("R11 one cycle", coef_rst[6], 0);

        // R7 R8: signalling mapping
        tag = "R7";
        wr(2'd1, 32'h0000_00FA);
        wr(2'd0, 32'h0000_0FBD);
        ts16_vld = 1; ts16_frame = 4'd2; ts16_byte = 8'hA5; tick(); clear_in();
        ts16_vld = 1; ts16_frame = 4'd0; ts16_byte = 8'hAA; tick(); clear_in();
        slot(2); slot(17); slot(0);
        chk("R7 upper", dis_sub[2], 1); chk("R8 level 2", bypass[2], 0);
        chk("R7 lower", dis_nlp[17], 0); chk("R7 frame0", dis_nlp[0], 0);

        // R9: external request
        tag = "R9";
        wr(2'd2, 32'h0010_0200);
        slot(9); slot(20);
        chk("R9 ext", bypass[9], 1); chk("R9 ext hi", bypass[20], 1);

        // R10: long-tail clears upper half without strobe
        tag = "R10";
        wr(2'd0, 32'h0001_0FBD); tick();
        chk("R10 cleared", bypass[20], 0); chk("R11 no strobe", coef_rst[20], 0);
        slot(20); chk("R10 slot ignored", bypass[20], 0);
        chk("R10 lower kept", bypass[9], 1);

        // R12: unused address
        tag = "R12";
        wr(2'd3, 32'hFFFF_FFFF); slot(9); slot(2);
        chk("R12 none", bypass[9], 1); chk("R12 none sub", dis_sub[2], 1);
        wr(2'd0, 32'h0000_0F3D);

        // R3: random overlap of all causes against the model
        tag = "R3";
        for (int i = 0; i < 6000; i++) begin
            slot_stb = $urandom_range(0, 1); slot_ch = CW'($urandom);
            pl_on  = $urandom & $urandom & $urandom & $urandom;
            pl_off = $urandom & $urandom & $urandom;
            pr_on  = $urandom & $urandom & $urandom & $urandom;
            pr_off = $urandom & $urandom & $urandom;
            cc_on  = $urandom & $urandom & $urandom & $urandom;
            cc_off = $urandom & $urandom & $urandom;
            idle   = $urandom & $urandom;
            ts16_vld = $urandom_range(0, 3) == 0;
            ts16_frame = 4'($urandom); ts16_byte = 8'($urandom);
            cfg_we = $urandom_range(0, 40) == 0;
            cfg_addr = 2'($urandom); cfg_wdata = $urandom;
            if (cfg_addr == 2'd0) cfg_wdata[16] = ($urandom_range(0, 3) == 0);
            tick();
        end
        clear_in(); tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule